// File: doc/BRIEF.md
# Streaming Two-Stage Max Pooler

This block reduces a square feature map of signed fixed-point values by non-overlapping max pooling. A window of POOL × POOL values is replaced by its largest member, and the window steps by POOL in both directions. The map is MAP_SIZE values on a side. It enters one value per accepted clock in raster order, row by row and left to right. The result is a (MAP_SIZE/POOL) × (MAP_SIZE/POOL) map, which leaves in the same raster order.

The work is split into two stages. A horizontal stage reduces each run of POOL neighbouring values in a row to one maximum. It appends that maximum to one of POOL row-interleaved queues, picked by the input row number modulo POOL. When the last row of a band of POOL rows has been reduced, a vertical stage drains the queues. It pops the head of every queue at once and emits the largest of them, once per output column. It then waits for the next band.

The default configuration is 4 × 4 pooling on a 16 × 16 map. Setting POOL to 2 gives 2 × 2 pooling. MAP_SIZE must be a multiple of POOL.

Top module: `pool2stage`

## Requirements
- R1: While reset is held and directly after it, outValid and frameEnd are low.
- R2: Each output value equals the largest of the POOL × POOL input values in its window. The comparison treats values as two's complement signed numbers, so a positive value beats a negative one whatever their bit patterns.
- R3: Outputs appear in raster order of the pooled map: all MAP_SIZE/POOL windows of one band of rows, left to right, before any window of the next band.
- R4: A frame of MAP_SIZE × MAP_SIZE accepted inputs yields exactly (MAP_SIZE/POOL)² outputs.
- R5: Cycles with inValid low are ignored. Idle gaps anywhere inside a frame leave the output values and their order unchanged.
- R6: No output of a band appears before the final input value of that band's last row has been accepted.
- R7: The outputs of one band leave on MAP_SIZE/POOL consecutive cycles with outValid high.
- R8: frameEnd is a one-cycle pulse in the cycle right after the last output of a frame, with outValid low, once per frame.
- R9: Frames may follow each other with no idle cycle between them, and each frame is pooled on its own.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| inValid | input | 1 | Input value present this cycle |
| inData | input | DATA_W | Signed input value, raster order |
| outValid | output | 1 | Pooled value present this cycle |
| outData | output | DATA_W | Signed pooled value |
| frameEnd | output | 1 | One-cycle pulse after the last pooled value of a frame |

## Verification
The first frame is an increasing ramp. Its maximum always sits in the bottom-right corner of each window, so any slip in band or column indexing shows up as a wrong value or a wrong order. A second frame mixes negative and positive values inside the same windows, which catches an unsigned compare. A third has every value negative, and a fourth puts the peak at scattered positions, which catches a stage that keeps the first or last element instead of the maximum. The remaining runs repeat these data with idle gaps, with a long stall just before a band completes, and as two frames back to back. These check that stalls are ignored, that the vertical stage does not start early, and that the counters wrap cleanly at frame boundaries.

// File: rtl/pool_pkg.sv
package pool_pkg;

  // Strobes from the control unit to the datapath.
  typedef struct packed {
    logic rowLoad;   // an input value is accepted this cycle
    logic rowFirst;  // accepted value opens a horizontal window
    logic rowPush;   // accepted value closes a horizontal window
    logic colPop;    // vertical stage pops all queue heads
    logic colLast;   // the pop is the final one of the frame
  } poolStrobes_t;

  typedef enum logic [0:0] {
    COL_IDLE  = 1'b0,
    COL_DRAIN = 1'b1
  } colState_t;

endpackage

// File: rtl/pool_ctrl.sv
module pool_ctrl
  import pool_pkg::*;
#(
  parameter int MAP_SIZE = 16,
  parameter int POOL     = 4,
  localparam int OUT_W   = MAP_SIZE / POOL,
  localparam int CW      = (MAP_SIZE > 1) ? $clog2(MAP_SIZE) : 1,
  localparam int LW      = (POOL > 1) ? $clog2(POOL) : 1,
  localparam int OW      = (OUT_W > 1) ? $clog2(OUT_W) : 1
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          inValid,
  output poolStrobes_t  strobes,
  output logic [LW-1:0] fifoSel
);

  localparam logic [CW-1:0] LAST_COL  = CW'(MAP_SIZE - 1);
  localparam logic [LW-1:0] LAST_SLOT = LW'(POOL - 1);
  localparam logic [OW-1:0] LAST_OUT  = OW'(OUT_W - 1);

  // Horizontal stage position
  logic [CW-1:0] inCol;
  logic [LW-1:0] inGrp;
  logic [LW-1:0] rowSlot;
  logic          groupDone;

  // Vertical stage position
  colState_t     colState;
  logic [OW-1:0] outCol;
  logic [OW-1:0] outBand;

  assign groupDone = inValid && (inCol == LAST_COL) && (rowSlot == LAST_SLOT);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      inCol   <= '0;
      inGrp   <= '0;
      rowSlot <= '0;
    end else if (inValid) begin
      inGrp <= (inGrp == LAST_SLOT) ? '0 : inGrp + 1'b1;
      if (inCol == LAST_COL) begin
        inCol   <= '0;
        rowSlot <= (rowSlot == LAST_SLOT) ? '0 : rowSlot + 1'b1;
      end else begin
        inCol <= inCol + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      colState <= COL_IDLE;
      outCol   <= '0;
      outBand  <= '0;
    end else begin
      unique case (colState)
        COL_IDLE: begin
          if (groupDone) begin
            colState <= COL_DRAIN;
            outCol   <= '0;
          end
        end
        COL_DRAIN: begin
          if (outCol == LAST_OUT) begin
            outCol   <= '0;
            colState <= COL_IDLE;
            outBand  <= (outBand == LAST_OUT) ? '0 : outBand + 1'b1;
          end else begin
            outCol <= outCol + 1'b1;
          end
        end
        default: colState <= COL_IDLE;
      endcase
    end
  end

  always_comb begin
    strobes.rowLoad  = inValid;
    strobes.rowFirst = inValid && (inGrp == '0);
    strobes.rowPush  = inValid && (inGrp == LAST_SLOT);
    strobes.colPop   = (colState == COL_DRAIN);
    strobes.colLast  = (colState == COL_DRAIN) && (outCol == LAST_OUT)
                       && (outBand == LAST_OUT);
    fifoSel          = rowSlot;
  end

endmodule

// File: rtl/pool_datapath.sv
module pool_datapath
  import pool_pkg::*;
#(
  parameter int MAP_SIZE = 16,
  parameter int POOL     = 4,
  parameter int DATA_W   = 16,
  localparam int OUT_W   = MAP_SIZE / POOL,
  localparam int LW      = (POOL > 1) ? $clog2(POOL) : 1,
  localparam int OW      = (OUT_W > 1) ? $clog2(OUT_W) : 1
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic signed [DATA_W-1:0] inData,
  input  poolStrobes_t             strobes,
  input  logic [LW-1:0]            fifoSel,
  output logic                     outValid,
  output logic signed [DATA_W-1:0] outData,
  output logic                     frameEnd
);

  localparam logic [OW-1:0] LAST_PTR = OW'(OUT_W - 1);

  // Horizontal running maximum
  logic signed [DATA_W-1:0] runMax;
  logic signed [DATA_W-1:0] rowCand;

  always_comb begin
    if (strobes.rowFirst || (inData > runMax)) rowCand = inData;
    else                                      rowCand = runMax;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                runMax <= '0;
    else if (strobes.rowLoad) runMax <= rowCand;
  end

  // Row-interleaved queues, one per row slot
  logic signed [DATA_W-1:0] headVal [POOL];

  for (genvar f = 0; f < POOL; f++) begin : g_queue
    logic signed [DATA_W-1:0] mem [OUT_W];
    logic [OW-1:0] wrPtr;
    logic [OW-1:0] rdPtr;
    logic          wrEn;

    assign wrEn       = strobes.rowPush && (fifoSel == LW'(f));
    assign headVal[f] = mem[rdPtr];

    always_ff @(posedge clk) begin
      if (wrEn) mem[wrPtr] <= rowCand;
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        wrPtr <= '0;
        rdPtr <= '0;
      end else begin
        if (wrEn)
          wrPtr <= (wrPtr == LAST_PTR) ? '0 : wrPtr + 1'b1;
        if (strobes.colPop)
          rdPtr <= (rdPtr == LAST_PTR) ? '0 : rdPtr + 1'b1;
      end
    end
  end

  // Vertical maximum across queue heads
  logic signed [DATA_W-1:0] colMax;

  always_comb begin
    colMax = headVal[0];
    for (int f = 1; f < POOL; f++) begin
      if (headVal[f] > colMax) colMax = headVal[f];
    end
  end

  logic lastOut;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outValid <= 1'b0;
      outData  <= '0;
      lastOut  <= 1'b0;
      frameEnd <= 1'b0;
    end else begin
      outValid <= strobes.colPop;
      lastOut  <= strobes.colLast;
      frameEnd <= lastOut;
      if (strobes.colPop) outData <= colMax;
    end
  end

endmodule

// File: rtl/pool2stage.sv
module pool2stage
  import pool_pkg::*;
#(
  parameter int MAP_SIZE = 16,
  parameter int POOL     = 4,
  parameter int DATA_W   = 16
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     inValid,
  input  logic signed [DATA_W-1:0] inData,
  output logic                     outValid,
  output logic signed [DATA_W-1:0] outData,
  output logic                     frameEnd
);

  localparam int LW = (POOL > 1) ? $clog2(POOL) : 1;

  poolStrobes_t  strobes;
  logic [LW-1:0] fifoSel;

  pool_ctrl #(
    .MAP_SIZE(MAP_SIZE),
    .POOL    (POOL)
  ) u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .inValid(inValid),
    .strobes(strobes),
    .fifoSel(fifoSel)
  );

  pool_datapath #(
    .MAP_SIZE(MAP_SIZE),
    .POOL    (POOL),
    .DATA_W  (DATA_W)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .inData  (inData),
    .strobes (strobes),
    .fifoSel (fifoSel),
    .outValid(outValid),
    .outData (outData),
    .frameEnd(frameEnd)
  );

endmodule

// File: rtl/pool2stage_checker.sv
module pool2stage_checker #(
  parameter int MAP_SIZE = 16,
  parameter int POOL     = 4,
  parameter int DATA_W   = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              inValid,
  input logic [DATA_W-1:0] inData,
  input logic              outValid,
  input logic [DATA_W-1:0] outData,
  input logic              frameEnd
);

  localparam int OUT_W = MAP_SIZE / POOL;

  int runLen;
  int frameCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      runLen   <= 0;
      frameCnt <= 0;
    end else begin
      if (outValid) runLen <= $past(outValid) ? runLen + 1 : 1;
      if (frameEnd)      frameCnt <= 0;
      else if (outValid) frameCnt <= frameCnt + 1;
    end
  end

  // R1: outputs quiet while reset is held
  always @(posedge clk) begin
    if (!rstN) begin
      p_reset_quiet_r1: assert (!outValid && !frameEnd)
        else $error("outputs active during reset");
    end
  end

  // R7: each band leaves as one unbroken run of OUT_W values
  p_band_run_r7: assert property (@(posedge clk) disable iff (!rstN)
    $fell(outValid) |-> (runLen == OUT_W));

  // R4: every frame carries OUT_W*OUT_W outputs
  p_frame_count_r4: assert property (@(posedge clk) disable iff (!rstN)
    frameEnd |-> (frameCnt == OUT_W * OUT_W));

  // R8: frameEnd directly follows an output and does not overlap one
  p_fe_after_last_r8: assert property (@(posedge clk) disable iff (!rstN)
    frameEnd |-> ($past(outValid) && !outValid));

  // R8: frameEnd lasts one cycle
  p_fe_single_r8: assert property (@(posedge clk) disable iff (!rstN)
    frameEnd |=> !frameEnd);

endmodule

bind pool2stage pool2stage_checker #(
  .MAP_SIZE(MAP_SIZE),
  .POOL    (POOL),
  .DATA_W  (DATA_W)
) u_pool2stage_checker (
  .clk     (clk),
  .rstN    (rstN),
  .inValid (inValid),
  .inData  (inData),
  .outValid(outValid),
  .outData (outData),
  .frameEnd(frameEnd)
);

// File: tb/test_pool2stage.sv
`timescale 1ns/1ps
module test_pool2stage;

  localparam int K     = 16;
  localparam int L     = 4;
  localparam int DW    = 16;
  localparam int OUT_W = K / L;
  localparam int NOUT  = OUT_W * OUT_W;

  logic                 clk = 1'b0;
  logic                 rstN = 1'b0;
  logic                 inValid = 1'b0;
  logic signed [DW-1:0] inData = '0;
  logic                 outValid;
  logic signed [DW-1:0] outData;
  logic                 frameEnd;

  always #10 clk = ~clk;

  pool2stage #(.MAP_SIZE(K), .POOL(L), .DATA_W(DW)) i_pool2stage (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inData(inData),
    .outValid(outValid), .outData(outData), .frameEnd(frameEnd)
  );

  int vecCnt = 0;
  int failCnt = 0;
  int gotData [4096];
  int gotCnt = 0;
  int feCnt = 0;
  int feAt = 0;
  int curRun = 0;
  int runErr = 0;
  int expData [2*NOUT];
  bit finished = 0;

  // Output monitor, sampled away from the rising edge
  always @(negedge clk) begin
    if (outValid) begin
      if (gotCnt < 4096) gotData[gotCnt] = int'(outData);
      gotCnt++;
      curRun++;
    end else begin
      if (curRun != 0 && curRun != OUT_W) runErr++;
      curRun = 0;
    end
    if (frameEnd) begin
      feCnt++;
      feAt = gotCnt;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    vecCnt++;
    if (act !== exp) begin
      failCnt++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int genVal(input int mode, input int r, input int c);
    case (mode)
      0:       return r * K + c;
      1:       return ((r * 7 + c * 13) % 50) - 25;
      2:       return -1000 + (r * K + c) * 3;
      default: return 100 - (((r * K + c) * 37) % 97);
    endcase
  endfunction

  task automatic buildRef(input int mode, input int base);
    for (int br = 0; br < OUT_W; br++) begin
      for (int bc = 0; bc < OUT_W; bc++) begin
        int m = genVal(mode, br * L, bc * L);
        for (int i = 0; i < L; i++)
          for (int j = 0; j < L; j++)
            if (genVal(mode, br * L + i, bc * L + j) > m)
              m = genVal(mode, br * L + i, bc * L + j);
        expData[base + br * OUT_W + bc] = m;
      end
    end
  endtask

  task automatic feedFrame(input int mode, input bit gaps, input int pauseAt,
                           input int startCnt);
    for (int r = 0; r < K; r++) begin
      for (int c = 0; c < K; c++) begin
        int idx = r * K + c;
        if (idx == pauseAt) begin
          @(negedge clk) inValid = 1'b0;
          repeat (10) @(negedge clk);
          // R6: band not complete, nothing may have left yet
          chk("R6 outputs before band complete", gotCnt - startCnt, 0);
        end
        if (gaps && (idx % 3 == 1)) begin
          @(negedge clk) inValid = 1'b0;
          if (idx % 7 == 1) repeat (2) @(negedge clk);
        end
        @(negedge clk);
        inValid = 1'b1;
        inData  = DW'(genVal(mode, r, c));
      end
    end
  endtask

  task automatic goIdle();
    @(negedge clk) inValid = 1'b0;
    repeat (2 * OUT_W + 6) @(negedge clk);
  endtask

  task automatic checkOut(input string req, input int startCnt,
                          input int feStart, input int nFrames);
    int n = NOUT * nFrames;
    chk("R4 output count", gotCnt - startCnt, n);
    for (int i = 0; i < n; i++)
      chk(req, gotData[startCnt + i], expData[i]);
    chk("R8 frameEnd count", feCnt - feStart, nFrames);
    chk("R8 frameEnd position", feAt, startCnt + n);
    chk("R7 broken output runs", runErr, 0);
  endtask

  task automatic runOne(input string req, input int mode, input bit gaps,
                        input int pauseAt);
    int s = gotCnt;
    int f = feCnt;
    buildRef(mode, 0);
    feedFrame(mode, gaps, pauseAt, s);
    goIdle();
    checkOut(req, s, f, 1);
  endtask

  task automatic testReset();
    repeat (3) @(negedge clk);
    chk("R1 outValid in reset", int'(outValid), 0);
    chk("R1 frameEnd in reset", int'(frameEnd), 0);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 outValid after reset", int'(outValid), 0);
    chk("R1 frameEnd after reset", int'(frameEnd), 0);
  endtask

  task automatic testBackToBack();
    int s = gotCnt;
    int f = feCnt;
    buildRef(1, 0);
    buildRef(3, NOUT);
    feedFrame(1, 1'b0, -1, s);
    feedFrame(3, 1'b0, -1, s + NOUT);
    goIdle();
    checkOut("R9 back-to-back value", s, f, 2);
  endtask

  task automatic finishRun();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vecCnt, failCnt);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    vecCnt++;
    failCnt++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    testReset();
    runOne("R2 R3 ramp value", 0, 1'b0, -1);
    runOne("R2 signed mixed value", 1, 1'b0, -1);
    runOne("R2 all negative value", 2, 1'b0, -1);
    runOne("R2 scattered peak value", 3, 1'b0, -1);
    runOne("R5 value with idle gaps", 3, 1'b1, -1);
    runOne("R6 value after stall", 1, 1'b0, L * K - 1);
    testBackToBack();
    finishRun();
  end

endmodule